// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is the watchdog peripheral of a small microcontroller. Software reaches it through a byte-wide special-function-register port. That port offers a key register, a control register and a system configuration register. A 16-bit counter advances once for every system clock cycle in which a slow tick strobe is high. The strobe stands in for a separate low-rate oscillator. When the counter reaches the period picked by the control register, the block raises a chip reset request for a fixed number of clock cycles.

The control register is guarded by a key sequence. It ignores writes until the two bytes 0x1E and 0xE1 have been written to the key register one after the other. The reverse pair, 0xE1 then 0x1E, closes it again. A timeout acts as a local soft reset. It disables the counter, relocks the control register and clears the output-inhibit bit. It also sets a reset-cause flag. Only the external power-on or pin reset clears that flag, or software writing it to 0.

Top module: `keyguard_wdt`

## Requirements
- R1: After the external reset `por_n`, the control register (address 0x9F) and the configuration register (address 0xBF) both read 0x00, `wdt_rst_req` is 0, and the control register is locked.
- R2: While the control register is locked, a write to it leaves every bit unchanged.
- R3: Writing 0x1E and then 0xE1 to the key register (address 0x97), with no other key write in between, unlocks the control register. The control register takes bit 7 as the enable bit and bits 2:0 as the period select, and it reads them back in those positions.
- R4: If a key write of any value other than 0xE1 comes right after 0x1E, the unlock attempt is dropped and a following 0xE1 does not unlock.
- R5: While unlocked, writing 0xE1 and then 0x1E to the key register locks the control register again.
- R6: With the enable bit set and the tick strobe high in every cycle, the reset request rises after exactly 512·2^PS ticks, where PS is control bits 2:0.
- R7: Writing 1 to control bit 5 zeroes the counter, and the count then restarts. Bit 5 always reads as 0.
- R8: Each timeout drives `wdt_rst_req` high for exactly 4 consecutive system clock cycles.
- R9: A timeout clears the enable bit and the period select, and it relocks the control register.
- R10: A timeout sets configuration bit 7 in the same cycle that `wdt_rst_req` rises. The bit survives that timeout. Only `por_n`, or software writing bit 7 as 0, clears it.
- R11: The counter advances only in cycles where both the enable bit and `tick_en` are 1. With either one at 0, no timeout occurs.
- R12: Configuration bit 0 is readable and writable at any time and drives `out_inhibit`. Both `por_n` and a timeout clear it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| por_n | input | 1 | External power-on / pin reset, active low, asynchronous |
| tick_en | input | 1 | Slow tick strobe, sampled on `clk` |
| sfr_wr | input | 1 | Register write strobe |
| sfr_addr | input | 8 | Register address, for both read and write |
| sfr_wdata | input | 8 | Write data |
| sfr_rdata | output | 8 | Read data for `sfr_addr`, combinational |
| wdt_rst_req | output | 1 | Chip reset request pulse |
| out_inhibit | output | 1 | Configuration bit 0 |

## Verification
The key tracker is exercised with a correct unlock, with an unlock broken by a wrong second byte, with a relock and with writes made while locked. These cases separate a tracker that only looks at the last byte from one that demands the exact pair. The counter runs with the strobe held high at two period settings, so an off-by-one or a wrong shift in the period arithmetic shows up as a pulse one cycle early or late. It also runs with the strobe low and with the enable bit low, which tells apart gating by tick from gating by enable. A clear written mid-period, followed by probes at the old and the new expiry times, shows whether the restart actually took place. The flag is watched across a timeout, across a software clear and across the external reset.

// File: rtl/keyguard_wdt_pkg.sv
package keyguard_wdt_pkg;

  // Key tracker states: the lock side and the open side each have a "half" state.
  typedef enum logic [1:0] {
    KS_LOCKED      = 2'd0,
    KS_LOCKED_HALF = 2'd1,
    KS_OPEN        = 2'd2,
    KS_OPEN_HALF   = 2'd3
  } key_state_e;

  // Ticks until timeout for a given period select.
  function automatic int unsigned period_ticks(input int unsigned base_shift,
                                               input int unsigned sel);
    return 32'd1 << (base_shift + sel);
  endfunction

endpackage

// File: rtl/wdt_key_seq.sv
module wdt_key_seq #(
  parameter int         DATA_W = 8,
  parameter logic [7:0] KEY_A  = 8'h1E,
  parameter logic [7:0] KEY_B  = 8'hE1
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              soft_rst,
  input  logic              key_wr,
  input  logic [DATA_W-1:0] key_data,
  output logic              ctrl_open
);
  import keyguard_wdt_pkg::*;

  key_state_e state_q, state_d;

  wire is_a = (key_data == DATA_W'(KEY_A));
  wire is_b = (key_data == DATA_W'(KEY_B));

  always_comb begin
    state_d = state_q;
    if (key_wr) begin
      unique case (state_q)
        KS_LOCKED:      state_d = is_a ? KS_LOCKED_HALF : KS_LOCKED;
        KS_LOCKED_HALF: state_d = is_b ? KS_OPEN        : KS_LOCKED;
        KS_OPEN:        state_d = is_b ? KS_OPEN_HALF   : KS_OPEN;
        KS_OPEN_HALF:   state_d = is_a ? KS_LOCKED      : KS_OPEN;
        default:        state_d = KS_LOCKED;
      endcase
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)        state_q <= KS_LOCKED;
    else if (soft_rst) state_q <= KS_LOCKED;
    else               state_q <= state_d;
  end

  assign ctrl_open = (state_q == KS_OPEN) || (state_q == KS_OPEN_HALF);

  // R3: the control register only opens on the second key byte
  assert_open_on_second_key_R3: assert property (@(posedge clk) disable iff (!por_n)
    $rose(ctrl_open) |-> $past(key_wr && is_b && !soft_rst));

  // R5: the control register only closes on a key write or a timeout
  assert_close_on_key_R5: assert property (@(posedge clk) disable iff (!por_n)
    $fell(ctrl_open) |-> $past((key_wr && is_a) || soft_rst));

endmodule

// File: rtl/wdt_tick_counter.sv
module wdt_tick_counter #(
  parameter int CNT_W      = 16,
  parameter int PS_W       = 3,
  parameter int BASE_SHIFT = 9
) (
  input  logic            clk,
  input  logic            por_n,
  input  logic            run,
  input  logic            tick_en,
  input  logic            clr,
  input  logic [PS_W-1:0] ps,
  output logic            timeout
);
  import keyguard_wdt_pkg::*;

  localparam int LIM_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [LIM_W-1:0] limit;
  logic [LIM_W-1:0] cnt_next;
  logic             step;

  assign limit    = LIM_W'(period_ticks(BASE_SHIFT, 32'(ps)));
  assign cnt_next = {1'b0, cnt_q} + LIM_W'(1);
  assign step     = run && tick_en && !clr;
  assign timeout  = step && (cnt_next == limit);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                    cnt_q <= '0;
    else if (!run || clr || timeout) cnt_q <= '0;
    else if (tick_en)              cnt_q <= cnt_next[CNT_W-1:0];
  end

  // R11: a running counter steps by exactly one per tick
  assert_count_step_R11: assert property (@(posedge clk) disable iff (!por_n)
    (step && !timeout) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

  // R11: without enable and tick the count does not move up
  assert_count_hold_R11: assert property (@(posedge clk) disable iff (!por_n)
    (run && !tick_en && !clr) |=> $stable(cnt_q));

  // R7: a clear restarts the count from zero
  assert_clear_zero_R7: assert property (@(posedge clk) disable iff (!por_n)
    clr |=> (cnt_q == '0));

endmodule

// File: rtl/wdt_rst_stretch.sv
module wdt_rst_stretch #(
  parameter int PULSE_CYC = 4
) (
  input  logic clk,
  input  logic por_n,
  input  logic trigger,
  output logic rst_req
);
  localparam int SW = $clog2(PULSE_CYC + 1);

  logic [SW-1:0] left_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)          left_q <= '0;
    else if (trigger)    left_q <= SW'(PULSE_CYC);
    else if (left_q != '0) left_q <= left_q - SW'(1);
  end

  assign rst_req = (left_q != '0);

  // R8: a trigger starts a full-length pulse
  assert_pulse_start_R8: assert property (@(posedge clk) disable iff (!por_n)
    trigger |=> (rst_req && left_q == SW'(PULSE_CYC)));

  // R8: the pulse ends only once the last remaining cycle is used up
  assert_pulse_end_R8: assert property (@(posedge clk) disable iff (!por_n)
    $fell(rst_req) |-> ($past(left_q) == SW'(1)));

endmodule

// File: rtl/keyguard_wdt.sv
module keyguard_wdt #(
  parameter int         ADDR_W     = 8,
  parameter int         DATA_W     = 8,
  parameter int         CNT_W      = 16,
  parameter int         PS_W       = 3,
  parameter int         BASE_SHIFT = 9,
  parameter int         PULSE_CYC  = 4,
  parameter logic [7:0] ADDR_KEY   = 8'h97,
  parameter logic [7:0] ADDR_CTRL  = 8'h9F,
  parameter logic [7:0] ADDR_CFG   = 8'hBF,
  parameter logic [7:0] KEY_A      = 8'h1E,
  parameter logic [7:0] KEY_B      = 8'hE1
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              tick_en,
  input  logic              sfr_wr,
  input  logic [ADDR_W-1:0] sfr_addr,
  input  logic [DATA_W-1:0] sfr_wdata,
  output logic [DATA_W-1:0] sfr_rdata,
  output logic              wdt_rst_req,
  output logic              out_inhibit
);
  localparam int EN_BIT   = DATA_W - 1;
  localparam int CLR_BIT  = 5;
  localparam int FLAG_BIT = DATA_W - 1;
  localparam int INH_BIT  = 0;

  // Named internal events
  logic            hit_key, hit_ctrl, hit_cfg;
  logic            key_wr, ctrl_open, ctrl_wr, cfg_wr;
  logic            fire;
  logic            en_q, clr_q, flag_q, inh_q;
  logic [PS_W-1:0] ps_q;

  assign hit_key  = (sfr_addr == ADDR_W'(ADDR_KEY));
  assign hit_ctrl = (sfr_addr == ADDR_W'(ADDR_CTRL));
  assign hit_cfg  = (sfr_addr == ADDR_W'(ADDR_CFG));
  assign key_wr   = sfr_wr && hit_key;
  assign ctrl_wr  = sfr_wr && hit_ctrl && ctrl_open;
  assign cfg_wr   = sfr_wr && hit_cfg;

  wdt_key_seq #(.DATA_W(DATA_W), .KEY_A(KEY_A), .KEY_B(KEY_B)) u_keys (
    .clk(clk), .por_n(por_n), .soft_rst(fire),
    .key_wr(key_wr), .key_data(sfr_wdata), .ctrl_open(ctrl_open)
  );

  wdt_tick_counter #(.CNT_W(CNT_W), .PS_W(PS_W), .BASE_SHIFT(BASE_SHIFT)) u_count (
    .clk(clk), .por_n(por_n), .run(en_q), .tick_en(tick_en),
    .clr(clr_q), .ps(ps_q), .timeout(fire)
  );

  wdt_rst_stretch #(.PULSE_CYC(PULSE_CYC)) u_pulse (
    .clk(clk), .por_n(por_n), .trigger(fire), .rst_req(wdt_rst_req)
  );

  // Control register: a timeout wins over a same-cycle write
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      en_q  <= 1'b0;
      ps_q  <= '0;
      clr_q <= 1'b0;
    end else if (fire) begin
      en_q  <= 1'b0;
      ps_q  <= '0;
      clr_q <= 1'b0;
    end else begin
      clr_q <= ctrl_wr && sfr_wdata[CLR_BIT];
      if (ctrl_wr) begin
        en_q <= sfr_wdata[EN_BIT];
        ps_q <= sfr_wdata[PS_W-1:0];
      end
    end
  end

  // Configuration register: the flag is cleared only by por_n or software
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      flag_q <= 1'b0;
      inh_q  <= 1'b0;
    end else if (fire) begin
      flag_q <= 1'b1;
      inh_q  <= 1'b0;
    end else if (cfg_wr) begin
      if (!sfr_wdata[FLAG_BIT]) flag_q <= 1'b0;
      inh_q <= sfr_wdata[INH_BIT];
    end
  end

  assign out_inhibit = inh_q;

  always_comb begin
    sfr_rdata = '0;
    if (hit_ctrl) begin
      sfr_rdata[EN_BIT]     = en_q;
      sfr_rdata[PS_W-1:0]   = ps_q;
    end else if (hit_cfg) begin
      sfr_rdata[FLAG_BIT]   = flag_q;
      sfr_rdata[INH_BIT]    = inh_q;
    end
  end

  // R2: a locked control register ignores writes
  assert_locked_write_ignored_R2: assert property (@(posedge clk) disable iff (!por_n)
    (sfr_wr && hit_ctrl && !ctrl_open && !fire) |=> ($stable(en_q) && $stable(ps_q)));

  // R9: a timeout disables and relocks
  assert_timeout_disables_R9: assert property (@(posedge clk) disable iff (!por_n)
    fire |=> (!en_q && ps_q == '0 && !ctrl_open));

  // R10: the flag is set together with the rising reset request
  assert_flag_with_pulse_R10: assert property (@(posedge clk) disable iff (!por_n)
    $rose(wdt_rst_req) |-> flag_q);

  // R10: the flag falls only after a software write of 0
  assert_flag_clear_by_sw_R10: assert property (@(posedge clk) disable iff (!por_n)
    $fell(flag_q) |-> $past(cfg_wr && !sfr_wdata[FLAG_BIT]));

  // R12: a timeout clears the inhibit bit
  assert_inhibit_cleared_R12: assert property (@(posedge clk) disable iff (!por_n)
    fire |=> !out_inhibit);

  // R7: the clear bit is a one-cycle command
  assert_clear_self_R7: assert property (@(posedge clk) disable iff (!por_n)
    clr_q |=> !clr_q);

endmodule

// File: tb/keyguard_wdt_tb.sv
module keyguard_wdt_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_KEY = 8'h97, A_CTRL = 8'h9F, A_CFG = 8'hBF;
  localparam int K_RD = 0, K_RST = 1, K_INH = 2;

  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       tick_en = 1'b0;
  logic       sfr_wr = 1'b0;
  logic [7:0] sfr_addr = 8'h00;
  logic [7:0] sfr_wdata = 8'h00;
  logic [7:0] sfr_rdata;
  logic       wdt_rst_req, out_inhibit;

  int checks = 0;
  int errors = 0;
  logic mon_go = 1'b0;
  logic finished = 1'b0;

  typedef struct {
    int         kind;
    logic [7:0] exp;
    string      tag;
  } exp_item_t;
  exp_item_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  keyguard_wdt u_dut (
    .clk(clk), .por_n(por_n), .tick_en(tick_en), .sfr_wr(sfr_wr),
    .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata),
    .wdt_rst_req(wdt_rst_req), .out_inhibit(out_inhibit)
  );

  // Monitor: pops expected items and compares them at the falling edge
  always @(negedge clk) begin
    if (mon_go) begin
      while (sb_q.size() > 0) begin
        exp_item_t it;
        logic [7:0] act;
        it = sb_q.pop_front();
        case (it.kind)
          K_RST:   act = {7'd0, wdt_rst_req};
          K_INH:   act = {7'd0, out_inhibit};
          default: act = sfr_rdata;
        endcase
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s: actual=%02h expected=%02h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic nxt();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    nxt();
    sfr_wr = 1'b1; sfr_addr = a; sfr_wdata = d;
    nxt();
    sfr_wr = 1'b0;
  endtask

  // Driver: pushes one expected item and lets the monitor sample it
  task automatic chk(input int kind, input logic [7:0] a, input logic [7:0] e,
                     input string tag);
    exp_item_t it;
    sfr_addr = a;
    it.kind = kind; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    mon_go = 1'b1;
    @(negedge clk);
    #1;
    mon_go = 1'b0;
  endtask

  task automatic unlock();
    wr(A_KEY, 8'h1E);
    wr(A_KEY, 8'hE1);
  endtask

  initial begin
    por_n = 1'b0;
    repeat (3) nxt();
    por_n = 1'b1;
    nxt();

    // R1 reset state
    chk(K_RD, A_CTRL, 8'h00, "R1 ctrl after reset");
    chk(K_RD, A_CFG, 8'h00, "R1 cfg after reset");
    chk(K_RST, A_CFG, 8'h00, "R1 rst_req after reset");

    // R2 locked write ignored
    wr(A_CTRL, 8'h87);
    chk(K_RD, A_CTRL, 8'h00, "R2 locked write");

    // R4 broken unlock
    wr(A_KEY, 8'h1E);
    wr(A_KEY, 8'h55);
    wr(A_KEY, 8'hE1);
    wr(A_CTRL, 8'h87);
    chk(K_RD, A_CTRL, 8'h00, "R4 broken unlock");

    // R3 unlock and write
    unlock();
    wr(A_CTRL, 8'h07);
    chk(K_RD, A_CTRL, 8'h07, "R3 unlocked write");

    // R11 ticks without enable
    tick_en = 1'b1;
    repeat (600) nxt();
    chk(K_RST, A_CTRL, 8'h00, "R11 disabled ticks");

    // R5 relock
    wr(A_KEY, 8'hE1);
    wr(A_KEY, 8'h1E);
    wr(A_CTRL, 8'h00);
    chk(K_RD, A_CTRL, 8'h07, "R5 relocked write");

    // R11 enable without ticks
    unlock();
    tick_en = 1'b0;
    wr(A_CTRL, 8'h80);
    repeat (600) nxt();
    chk(K_RST, A_CTRL, 8'h00, "R11 enabled without ticks");
    wr(A_CTRL, 8'h00);

    // R12 inhibit bit
    wr(A_CFG, 8'h01);
    chk(K_RD, A_CFG, 8'h01, "R12 cfg inhibit readback");
    chk(K_INH, A_CFG, 8'h01, "R12 out_inhibit high");

    // R6, R8, R9 timeout with PS=0 (512 ticks)
    tick_en = 1'b1;
    wr(A_CTRL, 8'h80);
    repeat (511) nxt();
    chk(K_RST, A_CTRL, 8'h00, "R6 no reset at tick 511");
    nxt();
    chk(K_RST, A_CTRL, 8'h01, "R6 R8 reset at tick 512");
    for (int i = 0; i < 3; i++) begin
      nxt();
      chk(K_RST, A_CTRL, 8'h01, "R8 pulse held");
    end
    nxt();
    chk(K_RST, A_CTRL, 8'h00, "R8 pulse ended after 4");
    chk(K_RD, A_CTRL, 8'h00, "R9 ctrl cleared by timeout");
    chk(K_RD, A_CFG, 8'h80, "R10 R12 cfg after timeout");
    chk(K_INH, A_CFG, 8'h00, "R12 out_inhibit cleared");
    wr(A_CTRL, 8'h87);
    chk(K_RD, A_CTRL, 8'h00, "R9 relocked after timeout");

    // R7 clear mid-period
    unlock();
    wr(A_CTRL, 8'h80);
    repeat (399) nxt();
    wr(A_CTRL, 8'hA0);
    chk(K_RD, A_CTRL, 8'h80, "R7 clear bit reads 0");
    repeat (112) nxt();
    chk(K_RST, A_CTRL, 8'h00, "R7 old expiry skipped");
    repeat (400) nxt();
    chk(K_RST, A_CTRL, 8'h00, "R7 no reset before restart end");
    nxt();
    chk(K_RST, A_CTRL, 8'h01, "R7 reset 512 after clear");
    repeat (4) nxt();
    chk(K_RST, A_CTRL, 8'h00, "R8 second pulse ended");

    // R10 flag survives, then software clear
    chk(K_RD, A_CFG, 8'h80, "R10 flag survives timeout");
    wr(A_CFG, 8'h00);
    chk(K_RD, A_CFG, 8'h00, "R10 software clear");

    // R6 PS=2 (2048 ticks)
    unlock();
    wr(A_CTRL, 8'h82);
    repeat (2047) nxt();
    chk(K_RST, A_CTRL, 8'h00, "R6 PS2 no reset at 2047");
    nxt();
    chk(K_RST, A_CTRL, 8'h01, "R6 PS2 reset at 2048");
    chk(K_RD, A_CFG, 8'h80, "R10 flag set again");

    // R10 external reset clears the flag
    repeat (6) nxt();
    por_n = 1'b0;
    repeat (2) nxt();
    por_n = 1'b1;
    nxt();
    chk(K_RD, A_CFG, 8'h00, "R10 R1 por clears flag");
    chk(K_RD, A_CTRL, 8'h00, "R1 ctrl after por");

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule